// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. A burst opens when either of two start strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the controller side. Either strobe loads the external address into the internal address register. After that, each cycle with the advance strobe high moves the two low address bits to the next position of a four-word burst. The upper bits keep the value they were loaded with.

The order-select input chooses between two orderings. Linear order adds the burst position to the starting low bits. Interleaved order XORs the burst position into them. A new external address may be loaded on any cycle, so the block also works as a plain registered address path when bursts are not used. The memory array, the data path and output enabling are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `curAddr` and `burstPos` to zero at that edge.
- R2: If `startCpu` or `startCtl` (or both) is high at a rising edge, `curAddr` takes the value of `extAddr` and `burstPos` becomes 0.
- R3: With `orderSel` = 0 (linear), an advance without a start sets the position to n = (`burstPos`+1) mod 4. The low two bits of `curAddr` become (s + n) mod 4, where s is the low two bits of the last loaded address.
- R4: With `orderSel` = 1 (interleaved), an advance without a start sets the low two bits to s XOR n, with s and n as in R3. Tying `orderSel` high gives the default interleaved behaviour.
- R5: An advance never changes `curAddr` above bit 1.
- R6: After four advances from a load, `burstPos` is 0 again and `curAddr` equals the loaded address.
- R7: When no start strobe and no advance is high at an edge, `curAddr` and `burstPos` keep their values.
- R8: When a start strobe and `advance` are high at the same edge, the load happens and the advance is ignored.
- R9: Start strobes on back-to-back cycles each load their own address, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| extAddr | input | ADDR_W | External address captured on a start |
| startCpu | input | 1 | Processor-side burst start strobe |
| startCtl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to next word of the burst |
| orderSel | input | 1 | 1 = interleaved order, 0 = linear order |
| curAddr | output | ADDR_W | Current internal word address |
| burstPos | output | 2 | Position within the burst, 0 to 3 |

## Verification
A start and an advance can arrive at the same edge. The start strobes can also arrive together and at the same edge as an advance. The bench provokes these collisions in directed steps and in a long random mix. A behavioural model tracks the starting low bits and the position as integers, and the design is compared with it after every edge. A colliding cycle is judged correct only if the design shows the freshly loaded address and position 0, not a stepped value.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic [CNT_W-1:0] nextPos;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             startCpu,
  input  logic             startCtl,
  input  logic             advance,
  output burstStrobes_t    strobes,
  output logic [CNT_W-1:0] posQ
);
  logic loadReq;
  logic stepReq;
  logic [CNT_W-1:0] posD;

  always_comb begin
    loadReq = startCpu | startCtl;
    stepReq = advance & ~loadReq;
    posD    = posQ;
    if (loadReq)      posD = '0;
    else if (stepReq) posD = posQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) posQ <= '0;
    else     posQ <= posD;
  end

  always_comb begin
    strobes.clear   = rst;
    strobes.load    = loadReq & ~rst;
    strobes.step    = stepReq & ~rst;
    strobes.nextPos = posD;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  burstStrobes_t     strobes,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrQ
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] startLowQ;
  logic [CNT_W-1:0] linLow;
  logic [CNT_W-1:0] ilvLow;
  logic [CNT_W-1:0] stepLow;

  always_comb begin
    linLow  = startLowQ + strobes.nextPos;
    ilvLow  = startLowQ ^ strobes.nextPos;
    stepLow = orderSel ? ilvLow : linLow;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      addrQ     <= '0;
      startLowQ <= '0;
    end else if (strobes.load) begin
      addrQ     <= extAddr;
      startLowQ <= extAddr[CNT_W-1:0];
    end else if (strobes.step) begin
      addrQ <= {addrQ[ADDR_W-1:CNT_W], stepLow};
    end
  end

  logic [UP_W-1:0] unusedUp;
  assign unusedUp = '0;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              startCpu,
  input  logic              startCtl,
  input  logic              advance,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  burstPos
);
  burstStrobes_t strobes;

  burst_ctrl ctrl_i (
    .clk(clk), .rst(rst), .startCpu(startCpu), .startCtl(startCtl),
    .advance(advance), .strobes(strobes), .posQ(burstPos)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .strobes(strobes), .extAddr(extAddr),
    .orderSel(orderSel), .addrQ(curAddr)
  );
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] extAddr,
  input logic              startCpu,
  input logic              startCtl,
  input logic              advance,
  input logic [ADDR_W-1:0] curAddr,
  input logic [1:0]        burstPos
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (curAddr == '0 && burstPos == 2'd0));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (startCpu || startCtl) |=> (curAddr == $past(extAddr) && burstPos == 2'd0));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && !startCpu && !startCtl) |=> $stable(curAddr[ADDR_W-1:2]));

  assert_pos_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !startCpu && !startCtl) |=> burstPos == 2'($past(burstPos) + 2'd1));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!advance && !startCpu && !startCtl) |=> ($stable(curAddr) && $stable(burstPos)));
endmodule

bind burst_addr_gen burst_addr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .extAddr(extAddr), .startCpu(startCpu),
  .startCtl(startCtl), .advance(advance), .curAddr(curAddr), .burstPos(burstPos)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int ADDR_W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] extAddr = '0;
  logic startCpu = 1'b0, startCtl = 1'b0, advance = 1'b0, orderSel = 1'b1;
  logic [ADDR_W-1:0] curAddr;
  logic [1:0] burstPos;

  int nCompared = 0, nMismatched = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .extAddr(extAddr), .startCpu(startCpu),
    .startCtl(startCtl), .advance(advance), .orderSel(orderSel),
    .curAddr(curAddr), .burstPos(burstPos)
  );

  int refAddr = 0, refStart = 0, refPos = 0;
  bit prevStart = 0;

  task automatic check(input string tag, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    string tag;
    int low;
    bit st, ad;
    st = startCpu | startCtl;
    ad = advance;
    if (rst) begin
      refAddr = 0; refStart = 0; refPos = 0; tag = "R1";
    end else if (st) begin
      refAddr = int'(extAddr); refStart = refAddr % 4; refPos = 0;
      tag = ad ? "R8" : (prevStart ? "R9" : "R2");
    end else if (ad) begin
      refPos = (refPos + 1) % 4;
      low = orderSel ? (refStart ^ refPos) : ((refStart + refPos) % 4);
      refAddr = (refAddr / 4) * 4 + low;
      tag = orderSel ? "R4" : "R3";
    end else tag = "R7";
    prevStart = st && !rst;
    #1;
    check({tag, " addr"}, int'(curAddr), refAddr);
    check({tag, " pos"}, int'(burstPos), refPos);
    if (ad && !st && !rst) check("R5 upper", int'(curAddr) / 4, refAddr / 4);
  end

  task automatic step(input bit sc, input bit sk, input bit ad, input bit os,
                      input logic [ADDR_W-1:0] a);
    @(negedge clk);
    startCpu = sc; startCtl = sk; advance = ad; orderSel = os; extAddr = a;
  endtask

  initial begin
    logic [ADDR_W-1:0] base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 reset addr", int'(curAddr), 0);
    // linear burst then wrap
    base = 18'h2A5C3 | 18'd2;
    step(1, 0, 0, 0, base);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, '0);
    step(0, 0, 0, 0, '0);
    @(posedge clk); #1;
    check("R6 linear wrap", int'(curAddr), int'(base));
    // interleaved burst via controller strobe
    base = 18'h1F001;
    step(0, 1, 0, 1, base);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, '0);
    step(0, 0, 0, 1, '0);
    @(posedge clk); #1;
    check("R6 interleaved wrap", int'(curAddr), int'(base));
    check("R6 pos wrap", int'(burstPos), 0);
    // collisions and back-to-back loads
    step(1, 1, 1, 1, 18'h00003);
    step(0, 1, 1, 0, 18'h3FFFE);
    step(1, 0, 0, 0, 18'h12345);
    step(0, 0, 1, 1, '0);
    step(0, 0, 0, 1, '0);
    // mid-burst reset
    step(0, 0, 1, 0, '0);
    rst = 1'b1;
    step(0, 0, 1, 0, '0);
    rst = 1'b0;
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 3) != 0,
           ($urandom % 2) == 1, ADDR_W'($urandom));
    end
    step(0, 0, 0, 0, '0);
    repeat (2) @(negedge clk);
    finished = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      nCompared++; nMismatched++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      finished = 1;
    end
  end

  initial begin
    wait (finished);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule